// File: doc/BRIEF.md
# Masked Wrapping Burst Address Counter

This block generates burst addresses for one port of a multiport memory. A 16-bit counter register holds the current address, and a mask register of the same width controls how it counts. Bits where the mask is 1 take part in counting. Bits where the mask is 0 are frozen. The low unmasked field therefore counts up and wraps back to zero, while the upper address bits stay fixed. If mask bit 0 is cleared, bit 0 of the address stays at its loaded value, so the counter steps by two. It then visits only even addresses or only odd addresses. Two ports driven this way can split a double-width word across even and odd locations.

Every control strobe is active low. A master reset acts asynchronously. All other strobes are sampled on the rising clock edge in a fixed priority: counter clear, then mask load, then counter load, then increment, then hold. Counter readback and mask readback run on a separate path. The requested value appears on a registered readback bus one cycle after the strobe is sampled. While a readback is pending, the block raises a request to float the data I/O. A one-cycle interrupt pulse marks each increment that brings the counting field back to zero.

Top module: `masked_burst_counter`

## Requirements
- R1: While `mrst_n` is low, with no clock edge needed, `addr_out` is 0x0000, the mask register is 0xFFFF, and `wrap_irq` and `rb_valid` are 0.
- R2: A sampled low `clr_n` sets `addr_out` to 0 and leaves the mask unchanged. It overrides any load or increment requested in the same cycle.
- R3: A sampled low `mask_ld_n` copies `addr_in` into the mask register. It outranks `cnt_ld_n`, so in that cycle the counter keeps its value.
- R4: A sampled low `cnt_ld_n`, with no higher-priority strobe low, copies `addr_in` into the counter. It outranks increment.
- R5: A sampled low `inc_n`, with no higher-priority strobe low, sets the counter to (c & ~m) | (((c | ~m) + 1) & m), where c is the counter and m is the mask. Bits where the mask is 0 never change. With mask 0x003F, counter 0x123F steps to 0x1200.
- R6: With mask bit 0 cleared, each increment keeps bit 0 and advances by two. Counter 0x0005 with mask 0xFFFE steps to 0x0007.
- R7: `wrap_irq` is high for exactly the one cycle after an increment whose new value ANDed with the mask is zero. Otherwise it is low.
- R8: If `cnt_rd_n` is sampled low, then after that edge `rb_valid` is 1 and `rb_data` holds the counter value from before the edge. Otherwise, if `mask_rd_n` is sampled low, `rb_data` holds the mask value from before the edge. Otherwise `rb_valid` is 0.
- R9: With every synchronous strobe high, the counter and mask keep their values.
- R10: `io_float` is high whenever `cnt_rd_n` or `mask_rd_n` is low, or `rb_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| clr_n | input | 1 | Synchronous counter clear, active low |
| cnt_ld_n | input | 1 | Counter load strobe, active low |
| mask_ld_n | input | 1 | Mask load strobe, active low |
| inc_n | input | 1 | Increment strobe, active low |
| cnt_rd_n | input | 1 | Counter readback strobe, active low |
| mask_rd_n | input | 1 | Mask readback strobe, active low |
| addr_in | input | 16 | Value for counter or mask load |
| addr_out | output | 16 | Current counter address |
| rb_data | output | 16 | Registered readback value |
| rb_valid | output | 1 | Readback value valid |
| wrap_irq | output | 1 | One-cycle wrap interrupt pulse |
| io_float | output | 1 | Request to tri-state the data I/O |

## Verification
The master reset is due at once, without a clock edge, so it is checked a nanosecond after it is asserted in the middle of a cycle. The counter, the mask, the wrap pulse and the readback data are all due at the first rising edge after the strobes are sampled. The bench drives on the falling edge and compares each of them at the next falling edge against a model that steps once per edge. `io_float` is combinational, so it is compared in the same half cycle against the strobes still applied and the modelled valid flag.

// File: rtl/masked_burst_counter.sv
module masked_burst_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         mrst_n,
  input  logic         clr_n,
  input  logic         cnt_ld_n,
  input  logic         mask_ld_n,
  input  logic         inc_n,
  input  logic         cnt_rd_n,
  input  logic         mask_rd_n,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] addr_out,
  output logic [W-1:0] rb_data,
  output logic         rb_valid,
  output logic         wrap_irq,
  output logic         io_float
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt, mask, step;

  assign step     = (cnt & ~mask) | (((cnt | ~mask) + ONE) & mask);
  assign addr_out = cnt;
  assign io_float = ~cnt_rd_n | ~mask_rd_n | rb_valid;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      cnt      <= '0;
      mask     <= ONES;
      wrap_irq <= 1'b0;
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else begin
      wrap_irq <= 1'b0;
      if (!cnt_rd_n) begin
        rb_data  <= cnt;
        rb_valid <= 1'b1;
      end else if (!mask_rd_n) begin
        rb_data  <= mask;
        rb_valid <= 1'b1;
      end else begin
        rb_valid <= 1'b0;
      end
      if (!clr_n)          cnt  <= '0;
      else if (!mask_ld_n) mask <= addr_in;
      else if (!cnt_ld_n)  cnt  <= addr_in;
      else if (!inc_n) begin
        cnt      <= step;
        wrap_irq <= ((step & mask) == '0);
      end
    end
  end

  a_r2_clear_keeps_mask: assert property (@(posedge clk) disable iff (!mrst_n)
    !clr_n |=> (addr_out == '0) && $stable(mask));
  a_r3_mask_beats_load: assert property (@(posedge clk) disable iff (!mrst_n)
    (clr_n && !mask_ld_n) |=> (mask == $past(addr_in)) && (addr_out == $past(addr_out)));
  a_r5_blocked_bits_frozen: assert property (@(posedge clk) disable iff (!mrst_n)
    (clr_n && mask_ld_n && cnt_ld_n && !inc_n) |=> (((addr_out ^ $past(addr_out)) & ~mask) == '0));
  a_r7_wrap_at_zero: assert property (@(posedge clk) disable iff (!mrst_n)
    wrap_irq |-> ((addr_out & mask) == '0));
  a_r7_wrap_one_cycle: assert property (@(posedge clk) disable iff (!mrst_n)
    wrap_irq |=> !wrap_irq || $past(!inc_n));
  a_r8_readback_valid: assert property (@(posedge clk) disable iff (!mrst_n)
    (!cnt_rd_n || !mask_rd_n) |=> rb_valid);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!mrst_n)
    (clr_n && mask_ld_n && cnt_ld_n && inc_n) |=> $stable(addr_out) && $stable(mask));
endmodule

// File: tb/masked_burst_counter_test.sv
`timescale 1ns/1ps
module masked_burst_counter_test;
  logic clk = 0;
  logic mrst_n, clr_n, cnt_ld_n, mask_ld_n, inc_n, cnt_rd_n, mask_rd_n;
  logic [15:0] addr_in, addr_out, rb_data;
  logic rb_valid, wrap_irq, io_float;
  int total = 0, bad = 0;
  logic [15:0] m_cnt, m_mask, m_rbd;
  logic m_rbv, m_wrap;

  always #2.5 clk = ~clk;

  masked_burst_counter uut (.clk(clk), .mrst_n(mrst_n), .clr_n(clr_n), .cnt_ld_n(cnt_ld_n),
    .mask_ld_n(mask_ld_n), .inc_n(inc_n), .cnt_rd_n(cnt_rd_n), .mask_rd_n(mask_rd_n),
    .addr_in(addr_in), .addr_out(addr_out), .rb_data(rb_data), .rb_valid(rb_valid),
    .wrap_irq(wrap_irq), .io_float(io_float));

  function automatic logic [15:0] nxt(input logic [15:0] c, input logic [15:0] m);
    return (c & ~m) | (((c | ~m) + 16'd1) & m);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive just after a falling edge, compare at the next falling edge
  task automatic cyc(input logic c, input logic ml, input logic cl, input logic in,
                     input logic cr, input logic mr, input logic [15:0] a);
    string tag;
    logic [15:0] n;
    clr_n = c; mask_ld_n = ml; cnt_ld_n = cl; inc_n = in;
    cnt_rd_n = cr; mask_rd_n = mr; addr_in = a;
    @(posedge clk);
    if (!cr) begin m_rbd = m_cnt; m_rbv = 1; end
    else if (!mr) begin m_rbd = m_mask; m_rbv = 1; end
    else m_rbv = 0;
    m_wrap = 0;
    if (!c) begin m_cnt = 0; tag = "R2"; end
    else if (!ml) begin m_mask = a; tag = "R3"; end
    else if (!cl) begin m_cnt = a; tag = "R4"; end
    else if (!in) begin
      n = nxt(m_cnt, m_mask);
      m_wrap = ((n & m_mask) == 0);
      m_cnt = n;
      tag = m_mask[0] ? "R5" : "R6";
    end else tag = "R9";
    @(negedge clk);
    check(tag, addr_out, m_cnt);
    check("R7", {15'd0, wrap_irq}, {15'd0, m_wrap});
    check("R8", {15'd0, rb_valid}, {15'd0, m_rbv});
    if (m_rbv) check("R8", rb_data, m_rbd);
    check("R10", {15'd0, io_float}, {15'd0, (!cr || !mr || m_rbv)});
  endtask

  task automatic rd_mask;
    cyc(1,1,1,1,1,0,16'h0);
  endtask

  initial begin
    #(5 * 20000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    mrst_n = 0; clr_n = 1; cnt_ld_n = 1; mask_ld_n = 1; inc_n = 1;
    cnt_rd_n = 1; mask_rd_n = 1; addr_in = 0;
    m_cnt = 0; m_mask = 16'hFFFF; m_rbd = 0; m_rbv = 0; m_wrap = 0;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    check("R1", addr_out, 16'h0000);
    check("R1", {14'd0, wrap_irq, rb_valid}, 16'h0);
    mrst_n = 1;
    rd_mask();
    check("R1", rb_data, 16'hFFFF);

    // R5: field 0x3F wraps, upper bits frozen; R7 pulse
    cyc(1,0,1,1,1,1,16'h003F);
    cyc(1,1,0,1,1,1,16'h123D);
    cyc(1,1,1,0,1,1,16'h0);
    check("R5", addr_out, 16'h123E);
    cyc(1,1,1,0,1,1,16'h0);
    cyc(1,1,1,0,1,1,16'h0);
    check("R5", addr_out, 16'h1200);
    check("R7", {15'd0, wrap_irq}, 16'h1);
    cyc(1,1,1,1,1,1,16'h0);
    check("R7", {15'd0, wrap_irq}, 16'h0);
    check("R9", addr_out, 16'h1200);

    // R6: even and odd stepping
    cyc(1,0,1,1,1,1,16'hFFFE);
    cyc(1,1,0,1,1,1,16'h0005);
    cyc(1,1,1,0,1,1,16'h0);
    check("R6", addr_out, 16'h0007);
    cyc(1,1,0,1,1,1,16'h0010);
    cyc(1,1,1,0,1,1,16'h0);
    check("R6", addr_out, 16'h0012);

    // R3: mask load outranks counter load
    cyc(1,0,0,0,1,1,16'h00FF);
    check("R3", addr_out, 16'h0012);
    rd_mask();
    check("R3", rb_data, 16'h00FF);

    // R2: clear beats everything, mask kept
    cyc(0,0,0,0,1,1,16'hAAAA);
    check("R2", addr_out, 16'h0000);
    rd_mask();
    check("R2", rb_data, 16'h00FF);

    // R8: counter readback beats mask readback
    cyc(1,1,0,1,1,1,16'h0042);
    cyc(1,1,1,0,0,0,16'h0);
    check("R8", rb_data, 16'h0042);
    check("R4", addr_out, 16'h0043);

    // R1: asynchronous master reset mid-cycle
    #1 mrst_n = 0;
    #1;
    check("R1", addr_out, 16'h0000);
    @(negedge clk);
    mrst_n = 1;
    m_cnt = 0; m_mask = 16'hFFFF; m_rbv = 0; m_wrap = 0;
    rd_mask();
    check("R1", rb_data, 16'hFFFF);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = $urandom;
      if ($urandom_range(0, 3) == 0) a = a & 16'hFFF0 | 16'h000F;
      cyc($urandom_range(0, 31) != 0, $urandom_range(0, 15) != 0,
          $urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, a);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule